// File: doc/BRIEF.md
# Floppy Interface Control Latch with Motor Hold

This block holds the eight control bits of a floppy disk interface card. The host sees the card as a window of sixteen I/O addresses. Any access to that window, read or write, changes exactly one control bit. The upper three address bits choose the bit, and the lowest address bit is the value written. The data bus plays no part in these updates. The bits drive four stepper phase lines, a raw motor request, a drive-select line and two mode bits for the read/write sequencer.

A retriggerable down-counter turns the raw motor request into a motor-on signal. The counter advances on a 2 MHz tick enable, so motor-on persists for a fixed number of ticks after the request drops. Motor-on and drive select produce the two drive enables, and those enables qualify the per-drive write-protect inputs. The card's read data comes from a multiplexer. It returns the sequencer's data shift register when the lowest address bit is 0 and a fixed stand-in for a floating bus when it is 1.

Top module: `fdcCtlLatch`

## Requirements
- R1: On a cycle with `accessStb` high, control bit number `addr[3:1]` takes the value `addr[0]` at the clock edge. The other seven bits keep their values.
- R2: The outputs map the control bits as follows. `phase[3:0]` are bits 3..0, `motorReq` is bit 4, `driveSel` is bit 5, and `modeBits[1:0]` are bits 7..6.
- R3: A synchronous active-high `rst` clears all eight control bits and the motor counter. After reset every output except `rdData` is 0.
- R4: On a tick while `motorReq` is 1, the motor counter reloads to MOTOR_HOLD (20). `motorOn` is 1 from the next cycle onward. `motorOn` stays 0 until the first tick after the request is set.
- R5: On a tick while `motorReq` is 0 and the counter is nonzero, the counter decrements by one. `motorOn` equals (counter != 0). After the last reload tick, `motorOn` stays 1 through 19 further ticks and drops on the 20th.
- R6: On a cycle without a tick, the motor counter holds its value.
- R7: `driveEn[0]` = !driveSel & motorOn and `driveEn[1]` = driveSel & motorOn. At most one enable is 1 at any time.
- R8: `rdData` equals `shiftData` when `addr[0]` is 0 and the constant 33 (0x21) when `addr[0]` is 1. The output is combinational.
- R9: `writeProt` = (driveEn[0] & wpIn[0]) | (driveEn[1] & wpIn[1]).
- R10: While `accessStb` is low, changes on `addr` leave all control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 2 MHz tick enable for the motor counter |
| accessStb | input | 1 | One-cycle strobe marking an access to the window |
| addr | input | 4 | Low address bits of the access |
| shiftData | input | 8 | Sequencer data shift register value |
| wpIn | input | 2 | Write-protect input from each drive |
| phase | output | 4 | Stepper phase lines |
| motorReq | output | 1 | Raw motor request bit |
| driveSel | output | 1 | Drive select bit |
| modeBits | output | 2 | Mode bits for the sequencer |
| motorOn | output | 1 | Stretched motor-on |
| driveEn | output | 2 | Per-drive enables |
| writeProt | output | 1 | Qualified write-protect |
| rdData | output | 8 | Read data multiplexer output |

## Verification
Some properties can be checked on every cycle. These are the single-bit update on an access, the hold of the latch without an access, the counter reload, the one-step decrement, the hold between ticks, and the mutual exclusion of the drive enables. Other behaviour needs the bench's scenarios. These are the exact count of 20 ticks of motor hold after the request drops, the absence of motor-on before the first tick, the sweep of all sixteen addresses from all-zero and all-one states, and the enable and write-protect outcomes over every drive-select, motor and write-protect combination.

// File: rtl/fdcCtlPkg.sv
package fdcCtlPkg;
  localparam int LatchBits = 8;
  localparam int IdxW = $clog2(LatchBits);

  // strobes from control to datapath
  typedef struct packed {
    logic            wrEn;
    logic [IdxW-1:0] bitIdx;
    logic            bitVal;
    logic            rdFloat;
    logic            cntReload;
    logic            cntDecay;
  } ctlStrobes_t;
endpackage

// File: rtl/fdcCtlControl.sv
module fdcCtlControl
  import fdcCtlPkg::*;
(
  input  logic        accessStb,
  input  logic [3:0]  addr,
  input  logic        tick,
  input  logic        motorReq,
  input  logic        motorOn,
  output ctlStrobes_t strb
);
  always_comb begin
    strb.wrEn      = accessStb;
    strb.bitIdx    = addr[3:1];
    strb.bitVal    = addr[0];
    strb.rdFloat   = addr[0];
    strb.cntReload = tick & motorReq;
    strb.cntDecay  = tick & ~motorReq & motorOn;
  end
endmodule

// File: rtl/fdcCtlDatapath.sv
module fdcCtlDatapath
  import fdcCtlPkg::*;
#(
  parameter int          MOTOR_HOLD  = 20,
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  FLOAT_VALUE = 8'd33
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strb,
  input  logic              tick,
  input  logic [DATA_W-1:0] shiftData,
  input  logic [1:0]        wpIn,
  output logic [LatchBits-1:0] latchQ,
  output logic              motorOn,
  output logic [1:0]        driveEn,
  output logic              writeProt,
  output logic [DATA_W-1:0] rdData
);
  localparam int CntW = $clog2(MOTOR_HOLD + 1);
  localparam logic [CntW-1:0] HoldVal = CntW'(MOTOR_HOLD);

  logic [CntW-1:0] holdCnt;
  logic            driveSelBit;

  // addressable latch, one flop per bit
  for (genvar i = 0; i < LatchBits; i++) begin : gBit
    always_ff @(posedge clk) begin
      if (rst)
        latchQ[i] <= 1'b0;
      else if (strb.wrEn && (strb.bitIdx == IdxW'(i)))
        latchQ[i] <= strb.bitVal;
    end
  end

  // retriggerable motor hold counter
  always_ff @(posedge clk) begin
    if (rst)
      holdCnt <= '0;
    else if (strb.cntReload)
      holdCnt <= HoldVal;
    else if (strb.cntDecay)
      holdCnt <= holdCnt - 1'b1;
  end

  assign motorOn     = (holdCnt != '0);
  assign driveSelBit = latchQ[5];
  assign driveEn[0]  = ~driveSelBit & motorOn;
  assign driveEn[1]  = driveSelBit & motorOn;
  assign writeProt   = |(driveEn & wpIn);
  assign rdData      = strb.rdFloat ? DATA_W'(FLOAT_VALUE) : shiftData;

  AST_ACCESS_WRITE: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |=> latchQ[$past(strb.bitIdx)] == $past(strb.bitVal)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.wrEn |=> $stable(latchQ)); // R10

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && latchQ[4]) |=> holdCnt == HoldVal); // R4

  AST_CNT_DECAY: assert property (@(posedge clk) disable iff (rst)
    (tick && !latchQ[4] && holdCnt != '0) |=> holdCnt == $past(holdCnt) - 1'b1); // R5

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(holdCnt)); // R6

  AST_ENABLE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones(driveEn) <= 1); // R7
endmodule

// File: rtl/fdcCtlLatch.sv
module fdcCtlLatch
  import fdcCtlPkg::*;
#(
  parameter int         MOTOR_HOLD  = 20,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] FLOAT_VALUE = 8'd33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              accessStb,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] shiftData,
  input  logic [1:0]        wpIn,
  output logic [3:0]        phase,
  output logic              motorReq,
  output logic              driveSel,
  output logic [1:0]        modeBits,
  output logic              motorOn,
  output logic [1:0]        driveEn,
  output logic              writeProt,
  output logic [DATA_W-1:0] rdData
);
  ctlStrobes_t          strb;
  logic [LatchBits-1:0] latchQ;

  fdcCtlControl uCtl (
    .accessStb (accessStb),
    .addr      (addr),
    .tick      (tick),
    .motorReq  (latchQ[4]),
    .motorOn   (motorOn),
    .strb      (strb)
  );

  fdcCtlDatapath #(
    .MOTOR_HOLD  (MOTOR_HOLD),
    .DATA_W      (DATA_W),
    .FLOAT_VALUE (FLOAT_VALUE)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .tick      (tick),
    .shiftData (shiftData),
    .wpIn      (wpIn),
    .latchQ    (latchQ),
    .motorOn   (motorOn),
    .driveEn   (driveEn),
    .writeProt (writeProt),
    .rdData    (rdData)
  );

  assign phase    = latchQ[3:0];
  assign motorReq = latchQ[4];
  assign driveSel = latchQ[5];
  assign modeBits = latchQ[7:6];
endmodule

// File: tb/tb_fdcCtlLatch.sv
module tb_fdcCtlLatch;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst, tick, accessStb;
  logic [3:0] addr;
  logic [7:0] shiftData;
  logic [1:0] wpIn;
  logic [3:0] phase;
  logic       motorReq, driveSel, motorOn, writeProt;
  logic [1:0] modeBits, driveEn;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdcCtlLatch dut (
    .clk(clk), .rst(rst), .tick(tick), .accessStb(accessStb), .addr(addr),
    .shiftData(shiftData), .wpIn(wpIn), .phase(phase), .motorReq(motorReq),
    .driveSel(driveSel), .modeBits(modeBits), .motorOn(motorOn),
    .driveEn(driveEn), .writeProt(writeProt), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outBits();
    return {modeBits, driveSel, motorReq, phase};
  endfunction

  task automatic access(input logic [3:0] a);
    @(negedge clk); addr = a; accessStb = 1'b1;
    @(negedge clk); accessStb = 1'b0;
    #1;
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b0; accessStb = 1'b0; addr = 4'h0;
    shiftData = 8'h00; wpIn = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b0; #1;
    // R3 reset state
    check("R3 latch", {24'd0, outBits()}, 32'h0);
    check("R3 motorOn", motorOn, 0);
    check("R3 driveEn", driveEn, 0);
    check("R3 writeProt", writeProt, 0);

    // R1 R2 sweep every address from all-zero and all-one states
    for (int base = 0; base < 2; base++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 8; b++) access(4'(b * 2 + base));
        model = base ? 8'hFF : 8'h00;
        access(4'(a));
        model[a >> 1] = a[0];
        check("R1 R2 single bit update", outBits(), model);
      end
    end

    // R10 addr changes without strobe
    model = outBits();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); addr = 4'(a);
    end
    @(negedge clk); #1;
    check("R10 no strobe no change", outBits(), model);

    // motor: clear everything
    for (int b = 0; b < 8; b++) access(4'(b * 2));
    access(4'h9);                           // bit4 = 1
    repeat (3) @(negedge clk); #1;
    check("R4 no motorOn before tick", motorOn, 0);
    pulseTick();
    check("R4 motorOn after reload tick", motorOn, 1);
    repeat (30) pulseTick();
    check("R4 request keeps motor on", motorOn, 1);
    access(4'h8);                           // bit4 = 0
    repeat (50) @(negedge clk); #1;
    check("R6 no tick holds", motorOn, 1);
    for (int t = 1; t <= HOLD; t++) begin
      pulseTick();
      check("R5 hold count", motorOn, (t < HOLD) ? 1 : 0);
    end
    pulseTick();
    check("R5 stays off", motorOn, 0);

    // R7 R9 enables and write protect
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        access(4'(10 + s));                 // drive select
        access(4'(8 + m));                  // motor request
        pulseTick();
        if (m == 0) repeat (HOLD) pulseTick();
        for (int w = 0; w < 4; w++) begin
          logic [1:0] en;
          @(negedge clk); wpIn = 2'(w); #1;
          en = m ? (s ? 2'b10 : 2'b01) : 2'b00;
          check("R7 driveEn", driveEn, en);
          check("R9 writeProt", writeProt, |(en & 2'(w)));
        end
      end
    end

    // R8 read mux
    for (int a = 0; a < 16; a++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk); addr = 4'(a); shiftData = 8'(p * 8'h5B + a); #1;
        check("R8 rdData", rdData, a[0] ? 8'd33 : 8'(p * 8'h5B + a));
      end
    end

    // R3 reset mid-operation
    access(4'hF); access(4'h9); pulseTick();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check("R3 reset clears latch", outBits(), 0);
    check("R3 reset clears motor", motorOn, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule